// File: doc/BRIEF.md
# Shared-Pin Half-Duplex Serial Port

This block is an asynchronous 8N1 serial port that uses one bidirectional pad for both directions. The transmitter drives the pad high and low only while it is sending a frame; otherwise the output enable is low and an external or pad pull-up holds the line high. Bytes to send arrive on a valid/ready pair. Received bytes leave on a data bus with a one-cycle valid strobe.

The receiver passes the pad input through a synchronizer. It arms start detection only after it has seen the line high. It samples each data bit at its centre and hands over the byte as soon as the eighth bit is taken, without waiting for the stop bit. While the block is transmitting, the receiver is held in its wait-for-high state, so the block never decodes its own frame. The bit time in clock cycles is an input, so one instance can serve many baud rates.

Top module: `shared_pin_uart`

## Requirements
- R1: After reset, `pad_oe` is 0, `tx_ready` is 1 and `rx_valid` is 0.
- R2: A byte accepted at a clock edge (`tx_valid` and `tx_ready` both high) starts its frame on that edge. The frame is a low start bit, then the eight data bits least significant first, then a high stop bit. Each bit lasts `bit_cycles` clocks, and `pad_oe` is 1 for the whole frame.
- R3: `tx_ready` is 1 when no frame is being sent and also in the final clock of a stop bit. A byte accepted in that final clock starts its start bit on the next clock, with no idle time between frames.
- R4: Whenever no frame is being sent, `pad_oe` is 0.
- R5: The receiver samples data bit k (k = 0..7) at `bit_cycles` + floor(`bit_cycles`/2) + k·`bit_cycles` clocks after it first sees the synchronized start edge. It assembles the bits least significant first.
- R6: `rx_valid` is a single-clock pulse with the byte on `rx_byte`. It rises 3 + 8·`bit_cycles` + floor(`bit_cycles`/2) clocks after the pad falls for the start bit (two synchronizer stages plus the detection register).
- R7: The stop bit is not checked: a frame whose stop bit is low still delivers its byte at the R6 time.
- R8: After delivering a byte, the receiver accepts no new start bit until it has seen the line high. A line held low past the eighth data bit produces no further byte.
- R9: While a frame is being transmitted, and because of it, no byte is received (`rx_valid` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_cycles | input | CNT_W | Clocks per bit (at least 4), held stable during frames |
| tx_byte | input | DATA_W | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte taken on this edge if valid |
| rx_byte | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-clock strobe: `rx_byte` is new |
| pad_o | output | 1 | Pad output level |
| pad_oe | output | 1 | Pad output enable (1 = drive) |
| pad_i | input | 1 | Pad input level |

## Verification
Each transmit frame is due on the edge that takes the byte. Each of its bits is expected across the `bit_cycles` clocks that follow. The bench samples every bit in the middle of its window and compares the frame's first clock with the acceptance edge. Each received byte is due exactly 3 + 8·`bit_cycles` + floor(`bit_cycles`/2) clocks after the start bit is driven. The scoreboard stores that cycle number with the byte and compares it with a free-running cycle count when the strobe appears. Checks run on falling edges, and stimulus changes there too. Any strobe with no entry waiting in the queue is flagged, which covers the suppression and re-arming cases.

// File: rtl/spu_pkg.sv
package spu_pkg;
   typedef enum logic [1:0] {
      RX_WAIT_HIGH = 2'd0,
      RX_ARMED     = 2'd1,
      RX_SHIFT     = 2'd2
   } rx_state_t;
endpackage

// File: rtl/spu_sync.sv
module spu_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RESET_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spu_tx.sv
module spu_tx #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  bit_cycles,
   input  logic [DATA_W-1:0] data,
   input  logic              valid,
   output logic              ready,
   output logic              line_o,
   output logic              line_oe
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int IDX_W   = $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

   logic               busy;
   logic [FRAME_W-1:0] frame;
   logic [IDX_W-1:0]   idx;
   logic [CNT_W-1:0]   tmr;
   logic               bit_end, frame_end, take;

   assign bit_end   = busy && (tmr == '0);
   assign frame_end = bit_end && (idx == LAST_IDX);
   assign ready     = !busy || frame_end;
   assign take      = valid && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         frame <= '1;
         idx   <= '0;
         tmr   <= '0;
      end else if (take) begin
         busy  <= 1'b1;
         frame <= {1'b1, data, 1'b0};
         idx   <= '0;
         tmr   <= bit_cycles - 1'b1;
      end else if (busy) begin
         if (frame_end) begin
            busy  <= 1'b0;
            frame <= '1;
         end else if (bit_end) begin
            frame <= {1'b1, frame[FRAME_W-1:1]};
            idx   <= idx + 1'b1;
            tmr   <= bit_cycles - 1'b1;
         end else begin
            tmr <= tmr - 1'b1;
         end
      end
   end

   assign line_o  = frame[0];
   assign line_oe = busy;
endmodule

// File: rtl/spu_rx.sv
module spu_rx #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  bit_cycles,
   input  logic              line_s,
   input  logic              hold_off,
   output logic [DATA_W-1:0] data,
   output logic              valid
);
   import spu_pkg::*;

   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   rx_state_t          state;
   logic [CNT_W:0]     tmr;
   logic [IDX_W-1:0]   idx;
   logic [DATA_W-1:0]  shreg;
   logic [CNT_W:0]     first_wait;
   logic [DATA_W-1:0]  shifted;

   // one and a half bit periods, minus the detection cycle
   assign first_wait = {1'b0, bit_cycles} + {2'b00, bit_cycles[CNT_W-1:1]} - 1'b1;
   assign shifted    = {line_s, shreg[DATA_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_WAIT_HIGH;
         tmr   <= '0;
         idx   <= '0;
         shreg <= '0;
         data  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (hold_off) begin
            state <= RX_WAIT_HIGH;
         end else begin
            unique case (state)
               RX_WAIT_HIGH: if (line_s) state <= RX_ARMED;
               RX_ARMED: if (!line_s) begin
                  state <= RX_SHIFT;
                  tmr   <= first_wait;
                  idx   <= '0;
               end
               RX_SHIFT: begin
                  if (tmr == '0) begin
                     shreg <= shifted;
                     if (idx == LAST_IDX) begin
                        data  <= shifted;
                        valid <= 1'b1;
                        state <= RX_WAIT_HIGH;
                     end else begin
                        idx <= idx + 1'b1;
                        tmr <= {1'b0, bit_cycles} - 1'b1;
                     end
                  end else begin
                     tmr <= tmr - 1'b1;
                  end
               end
               default: state <= RX_WAIT_HIGH;
            endcase
         end
      end
   end
endmodule

// File: rtl/shared_pin_uart.sv
module shared_pin_uart #(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  bit_cycles,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              pad_o,
   output logic              pad_oe,
   input  logic              pad_i
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("shared_pin_uart: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("shared_pin_uart: DATA_W must be at least 2");
      end
      if (CNT_W < 3) begin : g_bad_cnt
         $error("shared_pin_uart: CNT_W must be at least 3");
      end
   endgenerate

   logic line_s;

   spu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_i),
      .q     (line_s)
   );

   spu_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_cycles (bit_cycles),
      .data       (tx_byte),
      .valid      (tx_valid),
      .ready      (tx_ready),
      .line_o     (pad_o),
      .line_oe    (pad_oe)
   );

   spu_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_cycles (bit_cycles),
      .line_s     (line_s),
      .hold_off   (pad_oe),
      .data       (rx_byte),
      .valid      (rx_valid)
   );
endmodule

// File: rtl/spu_chk.sv
module spu_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_valid,
   input logic tx_ready,
   input logic pad_o,
   input logic pad_oe,
   input logic rx_valid
);
   // R2
   start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> (pad_oe && !pad_o));

   // R3
   no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && pad_oe) |=> pad_oe);

   // R4
   release_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe |-> tx_ready);

   // R6
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R9
   no_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe |-> !rx_valid);
endmodule

bind shared_pin_uart spu_chk i_spu_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .pad_o    (pad_o),
   .pad_oe   (pad_oe),
   .rx_valid (rx_valid)
);

// File: tb/test_shared_pin_uart.sv
module test_shared_pin_uart;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] bit_cycles;
   logic [7:0]       tx_byte = '0;
   logic             tx_valid = 1'b0;
   logic             tx_ready;
   logic [7:0]       rx_byte;
   logic             rx_valid;
   logic             pad_o, pad_oe, pad_i;
   logic             rem_oe = 1'b0, rem_o = 1'b1;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;
   int bit_c = 8;
   bit done = 0;

   int   rx_due_q[$];
   logic [7:0] rx_exp_q[$];
   logic [7:0] tx_exp_q[$];
   int   tx_start_q[$];

   assign pad_i = pad_oe ? pad_o : (rem_oe ? rem_o : 1'b1);
   assign bit_cycles = CNT_W'(bit_c);

   shared_pin_uart #(.DATA_W(8), .CNT_W(CNT_W), .SYNC_STAGES(2)) i_shared_pin_uart (
      .clk(clk), .rst_n(rst_n), .bit_cycles(bit_cycles),
      .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_byte(rx_byte), .rx_valid(rx_valid),
      .pad_o(pad_o), .pad_oe(pad_oe), .pad_i(pad_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic wait_cyc(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   // driver: offer one byte, return the edge that takes it
   task automatic send(input logic [7:0] b, output int acc);
      @(negedge clk);
      tx_byte  = b;
      tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      acc = cyc + 1;
      tx_exp_q.push_back(b);
      tx_start_q.push_back(acc);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   // remote transmitter on the shared line
   task automatic remote(input logic [7:0] b, input logic stop_lvl, input int extra_low, input bit expect_byte);
      @(negedge clk);
      rem_oe = 1'b1;
      rem_o  = 1'b0;
      if (expect_byte) begin
         rx_exp_q.push_back(b);
         rx_due_q.push_back(cyc + 3 + 8*bit_c + bit_c/2);
      end
      repeat (bit_c) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rem_o = b[i];
         repeat (bit_c) @(negedge clk);
      end
      rem_o = stop_lvl;
      repeat (bit_c + extra_low) @(negedge clk);
      rem_oe = 1'b0;
      rem_o  = 1'b1;
   endtask

   // receive monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && rx_valid) begin
            if (rx_exp_q.size() == 0) begin
               check(1'b0, "R8/R9 unexpected byte", int'(rx_byte), 0);
            end else begin
               logic [7:0] e;
               int due;
               e = rx_exp_q.pop_front();
               due = rx_due_q.pop_front();
               check(rx_byte == e, "R5 rx data", int'(rx_byte), int'(e));
               check(cyc == due, "R6 rx timing", cyc, due);
            end
         end
      end
   end

   // transmit monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && pad_oe && !pad_o) begin
            int k;
            logic [9:0] f;
            bit oe_ok;
            k = cyc;
            oe_ok = 1;
            for (int j = 0; j < 10; j++) begin
               wait_cyc(k + j*bit_c + bit_c/2);
               f[j] = pad_o;
               if (!pad_oe) oe_ok = 0;
            end
            check(oe_ok, "R2 pad_oe held", 0, 1);
            check(f[0] == 1'b0 && f[9] == 1'b1, "R2 start/stop", int'({f[9], f[0]}), 2);
            if (tx_exp_q.size() == 0) begin
               check(1'b0, "R2 unexpected frame", int'(f[8:1]), 0);
            end else begin
               logic [7:0] e;
               int s;
               e = tx_exp_q.pop_front();
               s = tx_start_q.pop_front();
               check(f[8:1] == e, "R2 tx data", int'(f[8:1]), int'(e));
               check(k == s, "R2 frame start edge", k, s);
            end
            wait_cyc(k + 10*bit_c - 1);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int a1, a2;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(pad_oe == 1'b0, "R1 pad_oe", int'(pad_oe), 0);
      check(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
      check(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);

      // R2 / R4 single frame at 8 clocks per bit
      send(8'hA5, a1);
      wait_cyc(a1 + 10*bit_c + 2);
      check(pad_oe == 1'b0, "R4 released after frame", int'(pad_oe), 0);
      check(tx_ready == 1'b1, "R3 ready when idle", int'(tx_ready), 1);

      // R3 back-to-back frames, R9 no echo
      send(8'h3C, a1);
      send(8'hC3, a2);
      check(a2 - a1 == 10*bit_c, "R3 zero gap", a2 - a1, 10*bit_c);
      wait_cyc(a2 + 10*bit_c + 40);
      check(pad_oe == 1'b0, "R4 released after burst", int'(pad_oe), 0);

      // R5 / R6 reception at 8 clocks per bit
      remote(8'h96, 1'b1, 0, 1);
      remote(8'h01, 1'b1, 0, 1);
      repeat (30) @(negedge clk);

      // odd bit time: half bit rounds down
      bit_c = 13;
      repeat (5) @(negedge clk);
      remote(8'h5A, 1'b1, 0, 1);
      remote(8'hFF, 1'b1, 0, 1);
      repeat (30) @(negedge clk);
      send(8'h00, a1);
      wait_cyc(a1 + 10*bit_c + 30);

      // R7 stop bit low still delivers
      remote(8'h35, 1'b0, 0, 1);
      repeat (30) @(negedge clk);

      // R8 line held low after bit 7 gives nothing more
      bit_c = 8;
      repeat (5) @(negedge clk);
      remote(8'h42, 1'b0, 3*8, 1);
      repeat (60) @(negedge clk);
      remote(8'h81, 1'b1, 0, 1);
      repeat (40) @(negedge clk);

      check(rx_exp_q.size() == 0, "R6 rx bytes outstanding", rx_exp_q.size(), 0);
      check(tx_exp_q.size() == 0, "R2 tx frames outstanding", tx_exp_q.size(), 0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule